// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Block

This block is the register file and interrupt collector that sits in front of a bank of sixteen DMA channel engines. Software programs each channel through a plain 32-bit register write/read port: a start address, an X length, a Y length, a control word and a per-channel line stride. The block presents every channel's settings to its engine as flat configuration vectors. It also issues a one-cycle start pulse when the channel's address register is written and a one-cycle stop pulse when software writes the channel stop register.

The engines return a one-cycle event pulse per channel. Each pulse latches into a status register that software clears by writing ones. An enable mask selects which latched events reach the single registered interrupt line. A loop-control register holds two enable bits per channel. A channel runs in loop mode only while both of its bits are set.

Channel register banks sit at a 16-byte stride from offset 0. The global registers sit above 0x100. Address bits [1:0] are ignored.

Top module: `dma_regfile`

## Requirements
- R1: For channel n, offsets n*0x10 + 0x0, 0x4 and 0x8 hold the 32-bit address, X length and Y length, which read back as written and appear on cfg_addr, cfg_xlen and cfg_ylen slice n. Offset n*0x10 + 0xC is the control word. Bits [5:0] are stored and bits [31:6] read as zero. Bit 4 drives cfg_burst[n] and bit 5 drives cfg_dir[n].
- R2: The 32-bit line stride of channel n lives at 0x100 + n*4, reads back as written and drives cfg_width slice n.
- R3: A write to channel n's address register makes start_o[n] high for exactly the one cycle after the write. Writes to any other register leave start_o at zero.
- R4: Status at 0x144 holds one bit per channel (bit n = channel n). A ch_event[n] pulse sets bit n, which is visible from the next cycle. Writing a 1 to bit n clears it, and writing 0 leaves it unchanged.
- R5: When ch_event[n] and a clearing write to status bit n occur in the same cycle, the bit ends up set.
- R6: The enable mask at 0x148 (bit n = channel n) reads back as written. irq_o is the OR over channels of status AND enable, delayed by one register. A set status bit whose enable bit is 0 never raises irq_o.
- R7: Writing a 1 to bit n of 0x140 makes stop_o[n] high for the one cycle after the write. The register reads as zero.
- R8: The loop register at 0x150 stores bit n and bit n+16 for channel n and reads them back in place. loop_mode[n] is 1 only when both bits are set, and clearing both returns it to 0.
- R9: Reads of unmapped offsets (for example 0x14C, 0x154, 0x1FC) return zero.
- R10: After reset every register, status bit, pulse output and irq_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ch_event | input | NCH | Per-channel event pulses from the engines |
| cfg_addr | output | NCH*32 | Start address of every channel |
| cfg_xlen | output | NCH*32 | X length of every channel |
| cfg_ylen | output | NCH*32 | Y length of every channel |
| cfg_width | output | NCH*32 | Line stride of every channel |
| cfg_burst | output | NCH | Burst-mode flag per channel |
| cfg_dir | output | NCH | Direction flag per channel |
| loop_mode | output | NCH | Channel is in loop mode |
| start_o | output | NCH | One-cycle start pulse per channel |
| stop_o | output | NCH | One-cycle stop pulse per channel |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The hardest case to reach from the ports is a channel event landing in the same clock edge as a software clear of the same status bit. The bench drives ch_event and the clearing write on the same falling edge, so both are sampled together at the next rising edge. It then reads the status back. A second hard case is an event on a masked channel. The bench latches that event with the channel disabled, confirms that irq_o stays low over several cycles, and then sets the enable bit. It expects irq_o to rise exactly one cycle after the enable takes effect.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 16,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [8:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NCH-1:0]    ch_event,
  output logic [NCH*DW-1:0] cfg_addr,
  output logic [NCH*DW-1:0] cfg_xlen,
  output logic [NCH*DW-1:0] cfg_ylen,
  output logic [NCH*DW-1:0] cfg_width,
  output logic [NCH-1:0]    cfg_burst,
  output logic [NCH-1:0]    cfg_dir,
  output logic [NCH-1:0]    loop_mode,
  output logic [NCH-1:0]    start_o,
  output logic [NCH-1:0]    stop_o,
  output logic              irq_o
);
  localparam int CW = 6;
  localparam logic [6:0] W_STOP = 7'h50;
  localparam logic [6:0] W_STAT = 7'h51;
  localparam logic [6:0] W_EN   = 7'h52;
  localparam logic [6:0] W_LOOP = 7'h54;

  logic [DW-1:0] addr_r  [NCH];
  logic [DW-1:0] xlen_r  [NCH];
  logic [DW-1:0] ylen_r  [NCH];
  logic [DW-1:0] width_r [NCH];
  logic [CW-1:0] ctrl_r  [NCH];
  logic [NCH-1:0] status_r, enable_r, loop_lo, loop_hi;

  wire       is_glob  = reg_addr[8];
  wire [3:0] sel_ch   = reg_addr[7:4];
  wire [1:0] sel_off  = reg_addr[3:2];
  wire [3:0] sel_w    = reg_addr[5:2];
  wire       is_wtab  = is_glob && (reg_addr[7:6] == 2'b00);
  wire       wr_stop  = reg_wr && (reg_addr[8:2] == W_STOP);
  wire       wr_stat  = reg_wr && (reg_addr[8:2] == W_STAT);
  wire       wr_en    = reg_wr && (reg_addr[8:2] == W_EN);
  wire       wr_loop  = reg_wr && (reg_addr[8:2] == W_LOOP);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [3:0] IDX = 4'(n);
    wire hit = reg_wr && !is_glob && (sel_ch == IDX);
    wire hit_w = reg_wr && is_wtab && (sel_w == IDX);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_r[n]  <= '0;
        xlen_r[n]  <= '0;
        ylen_r[n]  <= '0;
        ctrl_r[n]  <= '0;
        width_r[n] <= '0;
        start_o[n] <= 1'b0;
      end else begin
        if (hit && sel_off == 2'd0) addr_r[n] <= reg_wdata;
        if (hit && sel_off == 2'd1) xlen_r[n] <= reg_wdata;
        if (hit && sel_off == 2'd2) ylen_r[n] <= reg_wdata;
        if (hit && sel_off == 2'd3) ctrl_r[n] <= reg_wdata[CW-1:0];
        if (hit_w) width_r[n] <= reg_wdata;
        start_o[n] <= hit && (sel_off == 2'd0);
      end
    end

    assign cfg_addr[n*DW +: DW]  = addr_r[n];
    assign cfg_xlen[n*DW +: DW]  = xlen_r[n];
    assign cfg_ylen[n*DW +: DW]  = ylen_r[n];
    assign cfg_width[n*DW +: DW] = width_r[n];
    assign cfg_burst[n] = ctrl_r[n][4];
    assign cfg_dir[n]   = ctrl_r[n][5];
  end

  assign loop_mode = loop_lo & loop_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_r <= '0;
      enable_r <= '0;
      loop_lo  <= '0;
      loop_hi  <= '0;
      stop_o   <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_r <= (status_r & ~(wr_stat ? reg_wdata[NCH-1:0] : '0)) | ch_event;
      if (wr_en) enable_r <= reg_wdata[NCH-1:0];
      if (wr_loop) begin
        loop_lo <= reg_wdata[NCH-1:0];
        loop_hi <= reg_wdata[16 +: NCH];
      end
      stop_o <= wr_stop ? reg_wdata[NCH-1:0] : '0;
      irq_o  <= |(status_r & enable_r);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!is_glob) begin
      if (int'(sel_ch) < NCH) begin
        case (sel_off)
          2'd0: reg_rdata = addr_r[sel_ch];
          2'd1: reg_rdata = xlen_r[sel_ch];
          2'd2: reg_rdata = ylen_r[sel_ch];
          default: reg_rdata[CW-1:0] = ctrl_r[sel_ch];
        endcase
      end
    end else if (is_wtab) begin
      if (int'(sel_w) < NCH) reg_rdata = width_r[sel_w];
    end else begin
      case (reg_addr[8:2])
        W_STAT: reg_rdata[NCH-1:0] = status_r;
        W_EN:   reg_rdata[NCH-1:0] = enable_r;
        W_LOOP: begin
          reg_rdata[NCH-1:0]   = loop_lo;
          reg_rdata[16 +: NCH] = loop_hi;
        end
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

module dma_regfile_chk #(
  parameter int NCH = 16,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [8:0]     reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic [NCH-1:0] ch_event,
  input logic [NCH-1:0] start_o,
  input logic [NCH-1:0] stop_o,
  input logic [NCH-1:0] status_r,
  input logic [NCH-1:0] enable_r,
  input logic           irq_o
);
  wire addr_wr = reg_wr && !reg_addr[8] && (reg_addr[3:2] == 2'd0) && (int'(reg_addr[7:4]) < NCH);
  wire any_addr_wr = reg_wr && !reg_addr[8] && (reg_addr[3:2] == 2'd0);

  // R3
  start_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> $countones(start_o) == 1);

  // R3
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_addr_wr |=> start_o == '0);

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr[8:2] == 7'h50) |=> stop_o == '0);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_event != '0) |=> ((status_r & $past(ch_event)) == $past(ch_event)));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[8:2] == 7'h51 && ch_event == '0)
      |=> ((status_r & $past(reg_wdata[NCH-1:0])) == '0));

  // R6
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_r & enable_r) == '0) |=> !irq_o);
endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ch_event(ch_event), .start_o(start_o),
  .stop_o(stop_o), .status_r(status_r), .enable_r(enable_r), .irq_o(irq_o)
);

// File: tb/dma_regfile_tb_top.sv
module dma_regfile_tb_top;
  localparam int NCH = 16;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [8:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NCH-1:0] ch_event = '0;
  logic [NCH*DW-1:0] cfg_addr, cfg_xlen, cfg_ylen, cfg_width;
  logic [NCH-1:0] cfg_burst, cfg_dir, loop_mode, start_o, stop_o;
  logic irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_regfile #(.NCH(NCH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_event(ch_event),
    .cfg_addr(cfg_addr), .cfg_xlen(cfg_xlen), .cfg_ylen(cfg_ylen),
    .cfg_width(cfg_width), .cfg_burst(cfg_burst), .cfg_dir(cfg_dir),
    .loop_mode(loop_mode), .start_o(start_o), .stop_o(stop_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_ev(input logic [NCH-1:0] e);
    @(negedge clk);
    ch_event = e;
    @(negedge clk);
    ch_event = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(9'h144, d); chk("R10 status", d, 0);
    rd(9'h148, d); chk("R10 enable", d, 0);
    rd(9'h150, d); chk("R10 loop", d, 0);
    rd(9'h050, d); chk("R10 ch5 addr", d, 0);
    chk("R10 pulses", {start_o, stop_o}, 0);
    chk("R10 irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_chregs();
    logic [31:0] d;
    wr(9'h004, 32'h1111_0004);
    wr(9'h058, 32'h0000_0077);
    wr(9'h05C, 32'hFFFF_FFE5);
    wr(9'h0F4, 32'hDEAD_BEEF);
    wr(9'h0FC, 32'h0000_0010);
    rd(9'h004, d); chk("R1 ch0 xlen", d, 32'h1111_0004);
    rd(9'h058, d); chk("R1 ch5 ylen", d, 32'h77);
    rd(9'h05C, d); chk("R1 ch5 ctrl upper zero", d, 32'h25);
    chk("R1 ch5 burst/dir", {30'd0, cfg_dir[5], cfg_burst[5]}, 32'h2);
    rd(9'h0F4, d); chk("R1 ch15 xlen", d, 32'hDEAD_BEEF);
    chk("R1 cfg_xlen 15", cfg_xlen[15*32 +: 32], 32'hDEAD_BEEF);
    chk("R1 cfg_ylen 5", cfg_ylen[5*32 +: 32], 32'h77);
    chk("R1 ch15 burst", {31'd0, cfg_burst[15]}, 1);
  endtask

  task automatic t_width();
    logic [31:0] d;
    wr(9'h100, 32'h0000_0040);
    wr(9'h128, 32'h0000_0123);
    wr(9'h13C, 32'hCAFE_0001);
    rd(9'h128, d); chk("R2 width ch10", d, 32'h123);
    rd(9'h13C, d); chk("R2 width ch15", d, 32'hCAFE_0001);
    chk("R2 cfg_width ch0", cfg_width[0 +: 32], 32'h40);
    chk("R2 cfg_width ch10", cfg_width[10*32 +: 32], 32'h123);
  endtask

  task automatic t_start();
    wr(9'h070, 32'h8000_0000);
    chk("R3 start pulse ch7", {16'd0, start_o}, 32'h80);
    chk("R1 cfg_addr ch7", cfg_addr[7*32 +: 32], 32'h8000_0000);
    @(negedge clk);
    chk("R3 start one cycle", {16'd0, start_o}, 0);
    wr(9'h074, 32'h5);
    chk("R3 xlen write no start", {16'd0, start_o}, 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    pulse_ev(16'h8421);
    rd(9'h144, d); chk("R4 status set", d, 32'h8421);
    wr(9'h144, 32'h0000_0401);
    rd(9'h144, d); chk("R4 w1c partial", d, 32'h8020);
    wr(9'h144, 32'h0000_0000);
    rd(9'h144, d); chk("R4 write zero keeps", d, 32'h8020);
    wr(9'h144, 32'h0000_FFFF);
    rd(9'h144, d); chk("R4 clear all", d, 0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    pulse_ev(16'h0008);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 9'h144; reg_wdata = 32'h0000_0008; ch_event = 16'h0008;
    @(negedge clk);
    reg_wr = 1'b0; ch_event = '0;
    rd(9'h144, d); chk("R5 set beats clear", d, 32'h8);
    wr(9'h144, 32'h8);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(9'h148, 32'h0000_0002);
    rd(9'h148, d); chk("R6 enable readback", d, 32'h2);
    pulse_ev(16'h0100);
    repeat (3) @(negedge clk);
    chk("R6 masked no irq", {31'd0, irq_o}, 0);
    wr(9'h148, 32'h0000_0102);
    chk("R6 irq lag", {31'd0, irq_o}, 0);
    @(negedge clk);
    chk("R6 irq raised", {31'd0, irq_o}, 1);
    wr(9'h144, 32'h0000_0100);
    @(negedge clk);
    chk("R6 irq drops", {31'd0, irq_o}, 0);
    wr(9'h148, 32'h0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(9'h140, 32'h0000_8002);
    chk("R7 stop pulse", {16'd0, stop_o}, 32'h8002);
    @(negedge clk);
    chk("R7 stop one cycle", {16'd0, stop_o}, 0);
    rd(9'h140, d); chk("R7 reads zero", d, 0);
  endtask

  task automatic t_loop();
    logic [31:0] d;
    wr(9'h150, 32'h0000_0010);
    chk("R8 half set", {16'd0, loop_mode}, 0);
    wr(9'h150, 32'h0010_0010);
    chk("R8 both set", {16'd0, loop_mode}, 32'h10);
    rd(9'h150, d); chk("R8 readback", d, 32'h0010_0010);
    wr(9'h150, 32'h0010_0000);
    chk("R8 upper only", {16'd0, loop_mode}, 0);
    wr(9'h150, 32'h0);
    chk("R8 cleared", {16'd0, loop_mode}, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(9'h14C, d); chk("R9 0x14C", d, 0);
    rd(9'h154, d); chk("R9 0x154", d, 0);
    rd(9'h1FC, d); chk("R9 0x1FC", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_chregs();
    t_width();
    t_start();
    t_status();
    t_priority();
    t_irq();
    t_stop();
    t_loop();
    t_unmapped();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule